// File: doc/BRIEF.md
# Integer ALU with Status Flags

A purely combinational arithmetic and logic unit for a 32-bit integer execution stage. An operation code selects one of fourteen operations. The block applies it to two operands at an operand width of 8, 16 or 32 bits and returns the result, six status flags and two write enables in the same cycle. One enable marks the result as worth writing to a register. The other marks the flags as worth committing. Each operation carries its own flag rules, so the enables and flag values let the surrounding stage commit state without re-deriving them.

The flags are a carry (CF), a parity (PF), an auxiliary carry out of bit 3 (AF), a zero (ZF), a sign (SF) and a signed overflow (OF). An incoming carry feeds the carry-chain operations. It is also returned as CF by increment and decrement, which must not alter the carry. Register merging of partial-width results is left to the consumer: the result here is zero-extended above the selected width.

Top module: `int_alu_flags`

## Requirements
- R1: Operation codes are ADD=0, ADC=1, SUB=2, SBB=3, AND=4, OR=5, XOR=6, TEST=7, CMP=8, INC=9, DEC=10, NEG=11, NOT=12, MOV=13. ADD returns a+b and ADC returns a+b+cf_i. For both, CF is the carry out at the selected width, OF is signed overflow, and both write enables are 1.
- R2: SUB returns a-b and SBB returns a-b-cf_i. For both, CF is the borrow out at the selected width, OF is signed overflow, and both write enables are 1.
- R3: Width code 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Operand bits above the width are ignored, and result bits above it read zero.
- R4: AND, OR and XOR return the bitwise result with CF, OF and AF zero and both write enables 1.
- R5: CMP drives the SUB difference and its flags, and TEST drives the AND value and its flags. Both have the result write enable 0 and the flag write enable 1.
- R6: INC returns a+1 and DEC returns a-1. CF output equals cf_i, and the other five flags follow the result.
- R7: NEG returns 0-a, with CF=1 exactly when a is nonzero at the width, and all six flags written.
- R8: NOT returns the complement of a with the result write enable 1 and the flag write enable 0.
- R9: MOV returns b with the result write enable 1 and the flag write enable 0.
- R10: PF is 1 when the low 8 result bits hold an even number of ones. AF is the carry, or for subtract forms the borrow, out of bit 3.
- R11: SF is the result bit at the top of the selected width, and ZF is 1 when the result is zero at that width.
- R12: Whenever the flag write enable is 0, all six flag outputs read 0. Codes 14 and 15 return a zero result with both write enables 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (R1) |
| width_i | input | 2 | Operand width code (R3) |
| a_i | input | 32 | First operand (destination side) |
| b_i | input | 32 | Second operand (source side) |
| cf_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Result, zero above the width |
| cf_o | output | 1 | Carry flag |
| pf_o | output | 1 | Parity flag |
| af_o | output | 1 | Auxiliary carry flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Overflow flag |
| wr_result_o | output | 1 | Result should be written |
| wr_flags_o | output | 1 | Flags should be written |

## Verification
Several corner cases get their own stimulus. An increment whose sum carries out with cf_i low is one; a design that lets the adder's carry reach CF would return 1 there. A subtract-with-borrow that lands exactly on zero is another, and it catches an inverted borrow or a miswired carry-in through CF and ZF. An 8-bit negate of 0x80 and additions with junk above the width catch width handling. A design that took the carry or sign from bit 31 would report the wrong CF, SF and ZF. Finally, the compare, test, complement and move cases check the enables: a block that writes the compare result or leaks stale flags on complement shows it at wr_result_o or the flag pins.

// File: rtl/int_alu_pkg.sv
// Shared encodings for the integer ALU.
// Assumes a 32-bit datapath; 8- and 16-bit widths are sub-slices of it.
package int_alu_pkg;
    localparam int XLEN = 32;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,  OP_ADC  = 4'd1,  OP_SUB  = 4'd2,  OP_SBB  = 4'd3,
        OP_AND  = 4'd4,  OP_OR   = 4'd5,  OP_XOR  = 4'd6,  OP_TEST = 4'd7,
        OP_CMP  = 4'd8,  OP_INC  = 4'd9,  OP_DEC  = 4'd10, OP_NEG  = 4'd11,
        OP_NOT  = 4'd12, OP_MOV  = 4'd13
    } alu_op_e;

    typedef enum logic [1:0] {
        W_BYTE = 2'd0, W_HALF = 2'd1, W_WORD = 2'd2, W_WORD_ALT = 2'd3
    } alu_width_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0, LG_OR = 2'd1, LG_XOR = 2'd2, LG_NOT = 2'd3
    } logic_fn_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0, SRC_ARITH = 2'd1, SRC_LOGIC = 2'd2, SRC_MOVE = 2'd3
    } res_src_e;
endpackage

// File: rtl/alu_addsub.sv
// Width-aware adder/subtractor.
// Assumes operands arrive already masked to the selected width.
// Subtraction is a + ~b + cin; the caller chooses cin (1 for plain subtract).
module alu_addsub #(
    parameter int DW = int_alu_pkg::XLEN
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic [DW-1:0] mask_i,
    input  logic [1:0]    width_i,
    input  logic          sub_i,
    input  logic          cin_i,
    output logic [DW-1:0] sum_o,
    output logic          cout_o,
    output logic          ovf_o,
    output logic          aux_o
);
    localparam int HW = DW / 2;

    logic [DW-1:0] bx;
    logic [DW:0]   raw;
    logic          cin_msb;

    // Invert the second operand for subtract forms and add.
    always_comb begin
        bx  = sub_i ? (~b_i & mask_i) : b_i;
        raw = {1'b0, a_i} + {1'b0, bx} + {{DW{1'b0}}, cin_i};
    end

    // Pick the carry out and the carry into the top bit at the selected width.
    always_comb begin
        case (width_i)
            2'd0: begin
                cout_o  = raw[8];
                cin_msb = a_i[7] ^ bx[7] ^ raw[7];
            end
            2'd1: begin
                cout_o  = raw[HW];
                cin_msb = a_i[HW-1] ^ bx[HW-1] ^ raw[HW-1];
            end
            default: begin
                cout_o  = raw[DW];
                cin_msb = a_i[DW-1] ^ bx[DW-1] ^ raw[DW-1];
            end
        endcase
    end

    // Overflow, nibble carry (turned into a borrow for subtracts), masked sum.
    always_comb begin
        ovf_o = cin_msb ^ cout_o;
        aux_o = (a_i[4] ^ bx[4] ^ raw[4]) ^ sub_i;
        sum_o = raw[DW-1:0] & mask_i;
    end
endmodule

// File: rtl/alu_logic.sv
// Bitwise unit: AND, OR, XOR and complement of the first operand.
// Assumes masked operands; the complement is re-masked to the width.
module alu_logic #(
    parameter int DW = int_alu_pkg::XLEN
) (
    input  int_alu_pkg::logic_fn_e fn_i,
    input  logic [DW-1:0]          a_i,
    input  logic [DW-1:0]          b_i,
    input  logic [DW-1:0]          mask_i,
    output logic [DW-1:0]          res_o
);
    import int_alu_pkg::*;

    // Select the bitwise function.
    always_comb begin
        case (fn_i)
            LG_AND:  res_o = a_i & b_i;
            LG_OR:   res_o = a_i | b_i;
            LG_XOR:  res_o = a_i ^ b_i;
            default: res_o = ~a_i & mask_i;
        endcase
    end
endmodule

// File: rtl/alu_resflags.sv
// Result-derived flags: parity of the low byte, zero and sign at the width.
// Assumes the result is already zero above the selected width.
module alu_resflags #(
    parameter int DW = int_alu_pkg::XLEN
) (
    input  logic [DW-1:0] res_i,
    input  logic [1:0]    width_i,
    output logic          pf_o,
    output logic          zf_o,
    output logic          sf_o
);
    localparam int HW = DW / 2;

    // Parity, zero and the sign bit at the selected width.
    always_comb begin
        pf_o = ~(^res_i[7:0]);
        zf_o = (res_i == '0);
        case (width_i)
            2'd0:    sf_o = res_i[7];
            2'd1:    sf_o = res_i[HW-1];
            default: sf_o = res_i[DW-1];
        endcase
    end
endmodule

// File: rtl/int_alu_flags.sv
// Single-cycle integer ALU with per-operation status-flag rules.
// Assumes DW is 32 (8/16/32 widths); purely combinational, no state.
module int_alu_flags #(
    parameter int DW = int_alu_pkg::XLEN
) (
    input  logic [3:0]    op_i,
    input  logic [1:0]    width_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cf_i,
    output logic [DW-1:0] result_o,
    output logic          cf_o,
    output logic          pf_o,
    output logic          af_o,
    output logic          zf_o,
    output logic          sf_o,
    output logic          of_o,
    output logic          wr_result_o,
    output logic          wr_flags_o
);
    import int_alu_pkg::*;

    localparam int HW = DW / 2;

    logic [DW-1:0] mask, am, bm, add_a, add_b, sum, lres;
    logic          sub, cin, keep_cf, wr_res, wr_fl;
    logic          cout, ovf, aux, pf, zf, sf;
    logic_fn_e     lfn;
    res_src_e      src;

    // Width mask for operands and result.
    always_comb begin
        case (width_i)
            2'd0:    mask = DW'(8'hFF);
            2'd1:    mask = DW'({HW{1'b1}});
            default: mask = '1;
        endcase
        am = a_i & mask;
        bm = b_i & mask;
    end

    // Decode the operation into datapath and enable controls.
    always_comb begin
        src = SRC_NONE; lfn = LG_AND; sub = 1'b0; cin = 1'b0;
        keep_cf = 1'b0; wr_res = 1'b0; wr_fl = 1'b0;
        add_a = am; add_b = bm;
        case (op_i)
            OP_ADD:  begin src = SRC_ARITH; wr_res = 1'b1; wr_fl = 1'b1; end
            OP_ADC:  begin src = SRC_ARITH; cin = cf_i; wr_res = 1'b1; wr_fl = 1'b1; end
            OP_SUB:  begin src = SRC_ARITH; sub = 1'b1; cin = 1'b1; wr_res = 1'b1; wr_fl = 1'b1; end
            OP_SBB:  begin src = SRC_ARITH; sub = 1'b1; cin = ~cf_i; wr_res = 1'b1; wr_fl = 1'b1; end
            OP_AND:  begin src = SRC_LOGIC; lfn = LG_AND; wr_res = 1'b1; wr_fl = 1'b1; end
            OP_OR:   begin src = SRC_LOGIC; lfn = LG_OR;  wr_res = 1'b1; wr_fl = 1'b1; end
            OP_XOR:  begin src = SRC_LOGIC; lfn = LG_XOR; wr_res = 1'b1; wr_fl = 1'b1; end
            OP_TEST: begin src = SRC_LOGIC; lfn = LG_AND; wr_fl = 1'b1; end
            OP_CMP:  begin src = SRC_ARITH; sub = 1'b1; cin = 1'b1; wr_fl = 1'b1; end
            OP_INC:  begin src = SRC_ARITH; add_b = DW'(1); keep_cf = 1'b1;
                           wr_res = 1'b1; wr_fl = 1'b1; end
            OP_DEC:  begin src = SRC_ARITH; add_b = DW'(1); sub = 1'b1; cin = 1'b1;
                           keep_cf = 1'b1; wr_res = 1'b1; wr_fl = 1'b1; end
            OP_NEG:  begin src = SRC_ARITH; add_a = '0; add_b = am; sub = 1'b1; cin = 1'b1;
                           wr_res = 1'b1; wr_fl = 1'b1; end
            OP_NOT:  begin src = SRC_LOGIC; lfn = LG_NOT; wr_res = 1'b1; end
            OP_MOV:  begin src = SRC_MOVE; wr_res = 1'b1; end
            default: ;
        endcase
    end

    alu_addsub #(.DW(DW)) u_addsub (
        .a_i(add_a), .b_i(add_b), .mask_i(mask), .width_i(width_i),
        .sub_i(sub), .cin_i(cin), .sum_o(sum), .cout_o(cout),
        .ovf_o(ovf), .aux_o(aux)
    );

    alu_logic #(.DW(DW)) u_logic (
        .fn_i(lfn), .a_i(am), .b_i(bm), .mask_i(mask), .res_o(lres)
    );

    // Route the selected unit to the result port.
    always_comb begin
        case (src)
            SRC_ARITH: result_o = sum;
            SRC_LOGIC: result_o = lres;
            SRC_MOVE:  result_o = bm;
            default:   result_o = '0;
        endcase
    end

    alu_resflags #(.DW(DW)) u_resflags (
        .res_i(result_o), .width_i(width_i), .pf_o(pf), .zf_o(zf), .sf_o(sf)
    );

    // Assemble flags by operation class; all zero when not written.
    always_comb begin
        wr_result_o = wr_res;
        wr_flags_o  = wr_fl;
        if (!wr_fl) begin
            {cf_o, pf_o, af_o, zf_o, sf_o, of_o} = '0;
        end else if (src == SRC_ARITH) begin
            cf_o = keep_cf ? cf_i : (cout ^ sub);
            af_o = aux;
            of_o = ovf;
            pf_o = pf; zf_o = zf; sf_o = sf;
        end else begin
            cf_o = 1'b0; af_o = 1'b0; of_o = 1'b0;
            pf_o = pf; zf_o = zf; sf_o = sf;
        end
    end
endmodule

// File: rtl/int_alu_flags_chk.sv
// Property checker for int_alu_flags, attached by bind.
// Combinational block, so the checks are immediate assertions on settled values.
module int_alu_flags_chk #(
    parameter int DW = int_alu_pkg::XLEN
) (
    input logic [3:0]    op_i,
    input logic [1:0]    width_i,
    input logic [DW-1:0] a_i,
    input logic [DW-1:0] b_i,
    input logic          cf_i,
    input logic [DW-1:0] result_o,
    input logic          cf_o,
    input logic          pf_o,
    input logic          af_o,
    input logic          zf_o,
    input logic          sf_o,
    input logic          of_o,
    input logic          wr_result_o,
    input logic          wr_flags_o
);
    localparam int HW = DW / 2;

    logic [DW-1:0] wmask;

    // Independent width mask used by the checks.
    always_comb begin
        wmask = (width_i == 2'd0) ? DW'(8'hFF) :
                (width_i == 2'd1) ? DW'({HW{1'b1}}) : '1;
    end

    // Per-operation property checks.
    always_comb begin
        if (!$isunknown({op_i, width_i, a_i, b_i, cf_i})) begin
            if (op_i inside {4'd4, 4'd5, 4'd6, 4'd7})
                a_r4_logic_clears: assert (!cf_o && !of_o && !af_o)
                    else $error("logic op left CF/OF/AF set");
            if (op_i inside {4'd7, 4'd8})
                a_r5_no_result_write: assert (!wr_result_o && wr_flags_o)
                    else $error("compare/test enables wrong");
            if (op_i inside {4'd9, 4'd10})
                a_r6_carry_kept: assert (cf_o == cf_i)
                    else $error("inc/dec changed CF");
            if (op_i == 4'd11)
                a_r7_neg_carry: assert (cf_o == ((a_i & wmask) != '0))
                    else $error("negate CF wrong");
            if (op_i == 4'd12)
                a_r8_not_value: assert (!wr_flags_o && result_o == (~a_i & wmask))
                    else $error("complement wrong");
            a_r3_upper_zero: assert ((result_o & ~wmask) == '0)
                else $error("result bits above width");
            a_r12_quiet_flags: assert (wr_flags_o ||
                    {cf_o, pf_o, af_o, zf_o, sf_o, of_o} == 6'd0)
                else $error("flags driven without write");
        end
    end
endmodule

bind int_alu_flags int_alu_flags_chk #(.DW(DW)) u_chk (
    .op_i(op_i), .width_i(width_i), .a_i(a_i), .b_i(b_i), .cf_i(cf_i),
    .result_o(result_o), .cf_o(cf_o), .pf_o(pf_o), .af_o(af_o),
    .zf_o(zf_o), .sf_o(sf_o), .of_o(of_o),
    .wr_result_o(wr_result_o), .wr_flags_o(wr_flags_o)
);

// File: tb/int_alu_flags_bench.sv
// Vector-table bench for int_alu_flags, followed by directed corner tests.
module int_alu_flags_bench;
    typedef struct packed {
        logic [31:0] tag;
        logic [3:0]  op;
        logic [1:0]  w;
        logic [31:0] a;
        logic [31:0] b;
        logic        cf;
        logic [31:0] res;
        logic [5:0]  fl;   // {OF,SF,ZF,AF,PF,CF}
        logic        wr;
        logic        wf;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        {"R1",  4'd0,  2'd2, 32'hFFFFFFFF, 32'h00000001, 1'b0, 32'h00000000, 6'b001111, 1'b1, 1'b1},
        {"R1",  4'd0,  2'd2, 32'h7FFFFFFF, 32'h00000001, 1'b0, 32'h80000000, 6'b110110, 1'b1, 1'b1},
        {"R3",  4'd0,  2'd0, 32'h123456FF, 32'h00000001, 1'b0, 32'h00000000, 6'b001111, 1'b1, 1'b1},
        {"R1",  4'd1,  2'd1, 32'h00001234, 32'h00000001, 1'b1, 32'h00001236, 6'b000010, 1'b1, 1'b1},
        {"R1",  4'd1,  2'd2, 32'hFFFFFFFF, 32'h00000000, 1'b1, 32'h00000000, 6'b001111, 1'b1, 1'b1},
        {"R2",  4'd2,  2'd2, 32'h00000000, 32'h00000001, 1'b0, 32'hFFFFFFFF, 6'b010111, 1'b1, 1'b1},
        {"R2",  4'd2,  2'd2, 32'h80000000, 32'h00000001, 1'b0, 32'h7FFFFFFF, 6'b100110, 1'b1, 1'b1},
        {"R2",  4'd3,  2'd0, 32'h00000010, 32'h0000000F, 1'b1, 32'h00000000, 6'b001110, 1'b1, 1'b1},
        {"R2",  4'd3,  2'd2, 32'h00000005, 32'h00000005, 1'b1, 32'hFFFFFFFF, 6'b010111, 1'b1, 1'b1},
        {"R4",  4'd4,  2'd2, 32'hF0F0F0F0, 32'h0FF00FF0, 1'b1, 32'h00F000F0, 6'b000010, 1'b1, 1'b1},
        {"R11", 4'd5,  2'd1, 32'h00008000, 32'h00000001, 1'b0, 32'h00008001, 6'b010000, 1'b1, 1'b1},
        {"R4",  4'd6,  2'd2, 32'hDEADBEEF, 32'hDEADBEEF, 1'b0, 32'h00000000, 6'b001010, 1'b1, 1'b1},
        {"R5",  4'd7,  2'd2, 32'h80000000, 32'h80000000, 1'b1, 32'h80000000, 6'b010010, 1'b0, 1'b1},
        {"R5",  4'd8,  2'd2, 32'h00000003, 32'h00000005, 1'b0, 32'hFFFFFFFE, 6'b010101, 1'b0, 1'b1},
        {"R6",  4'd9,  2'd2, 32'h7FFFFFFF, 32'h00000000, 1'b1, 32'h80000000, 6'b110111, 1'b1, 1'b1},
        {"R6",  4'd9,  2'd0, 32'h000000FF, 32'h00000000, 1'b0, 32'h00000000, 6'b001110, 1'b1, 1'b1},
        {"R6",  4'd10, 2'd2, 32'h00000000, 32'h00000000, 1'b0, 32'hFFFFFFFF, 6'b010110, 1'b1, 1'b1},
        {"R10", 4'd10, 2'd1, 32'h00008000, 32'h00000000, 1'b1, 32'h00007FFF, 6'b100111, 1'b1, 1'b1},
        {"R7",  4'd11, 2'd2, 32'h00000000, 32'h00000000, 1'b0, 32'h00000000, 6'b001010, 1'b1, 1'b1},
        {"R7",  4'd11, 2'd2, 32'h00000001, 32'h00000000, 1'b0, 32'hFFFFFFFF, 6'b010111, 1'b1, 1'b1},
        {"R7",  4'd11, 2'd0, 32'h00000080, 32'h00000000, 1'b0, 32'h00000080, 6'b110001, 1'b1, 1'b1},
        {"R8",  4'd12, 2'd2, 32'h0F0F0F0F, 32'h00000000, 1'b1, 32'hF0F0F0F0, 6'b000000, 1'b1, 1'b0},
        {"R9",  4'd13, 2'd1, 32'h00000000, 32'hABCD1234, 1'b1, 32'h00001234, 6'b000000, 1'b1, 1'b0},
        {"R12", 4'd14, 2'd2, 32'h12345678, 32'h9ABCDEF0, 1'b1, 32'h00000000, 6'b000000, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op;
    logic [1:0]  width;
    logic [31:0] a, b, result;
    logic        cf, cf_o, pf_o, af_o, zf_o, sf_o, of_o, wr_res, wr_fl;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    int_alu_flags u_int_alu_flags (
        .op_i(op), .width_i(width), .a_i(a), .b_i(b), .cf_i(cf),
        .result_o(result), .cf_o(cf_o), .pf_o(pf_o), .af_o(af_o),
        .zf_o(zf_o), .sf_o(sf_o), .of_o(of_o),
        .wr_result_o(wr_res), .wr_flags_o(wr_fl)
    );

    // Drive one operation just after a clock edge.
    task automatic apply(input logic [3:0] o, input logic [1:0] w,
                         input logic [31:0] x, input logic [31:0] y, input logic c);
        @(posedge clk);
        op = o; width = w; a = x; b = y; cf = c;
        #4;
    endtask

    // Compare all outputs with the expected values.
    task automatic expect_out(input logic [31:0] tag, input logic [31:0] er,
                              input logic [5:0] ef, input logic ewr, input logic ewf);
        logic [5:0] got;
        got = {of_o, sf_o, zf_o, af_o, pf_o, cf_o};
        total++;
        if (result !== er || got !== ef || wr_res !== ewr || wr_fl !== ewf) begin
            bad++;
            $display("FAIL %0s op=%0d: got res=%h fl=%b wr=%b wf=%b exp res=%h fl=%b wr=%b wf=%b",
                     tag, op, result, got, wr_res, wr_fl, er, ef, ewr, ewf);
        end
    endtask

    initial begin
        op = 4'd0; width = 2'd0; a = '0; b = '0; cf = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #4;
        // Reset-time idle input (ADD of zeros): R11 zero flag, R10 parity.
        expect_out("R11", 32'h0, 6'b001010, 1'b1, 1'b1);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].w, VECS[i].a, VECS[i].b, VECS[i].cf);
            expect_out(VECS[i].tag, VECS[i].res, VECS[i].fl, VECS[i].wr, VECS[i].wf);
        end

        // R3: width code 3 behaves as 32 bits.
        apply(4'd0, 2'd3, 32'hFFFFFFFF, 32'h1, 1'b0);
        expect_out("R3", 32'h0, 6'b001111, 1'b1, 1'b1);
        // R3: junk above 16 bits is ignored on a 16-bit subtract.
        apply(4'd2, 2'd1, 32'hAAAA0005, 32'h55550003, 1'b0);
        expect_out("R3", 32'h2, 6'b000000, 1'b1, 1'b1);
        // R12: code 15 writes nothing and drives a zero result.
        apply(4'd15, 2'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1);
        expect_out("R12", 32'h0, 6'b000000, 1'b0, 1'b0);
        // R10: parity of low byte only (0x0300 has bits only above byte 0).
        apply(4'd13, 2'd2, 32'h0, 32'h00000300, 1'b0);
        expect_out("R9", 32'h00000300, 6'b000000, 1'b1, 1'b0);
        apply(4'd5, 2'd2, 32'h00000300, 32'h0, 1'b0);
        expect_out("R10", 32'h00000300, 6'b000010, 1'b1, 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule